// File: doc/BRIEF.md
# Translation Register Access Checker

This unit holds a small set of translation registers that let software reach memory by physical address without having to be trusted with arbitrary physical addresses. When a response arrives from the address-translation stub, it fills one register with a physical page number, the permission bits for that page and the virtual page it was looked up for. The same write sets a validity tag. Only such a response can set the tag. Any other write to the register clears the tag. An operating-system invalidate also clears it.

A load or store names a register, a byte offset and an access size. In one cycle the unit checks the access against the saved page. Either it grants the access with the physical address (page number joined with the in-page offset), or it traps with a cause code. Because the virtual page is kept, a re-translate command can send that page back to the stub after the mapping has changed. The stub's response then reloads the base and the permissions.

Top module: `xlat_cap_unit`

## Requirements
- R1: After reset every tag is clear, `acc_gnt_o`, `acc_trap_o` and `tlb_req_valid_o` are 0, and any access traps with cause 1.
- R2: A stub response (`tlb_rsp_valid_i`) to register n loads page number, permissions (bit 0 = read, bit 1 = write) and virtual page into n and sets its tag, visible to accesses from the next cycle on.
- R3: An access whose register has its tag set, lies inside the page and is permitted yields, one cycle later, `acc_gnt_o`=1, cause 0 and `acc_pa_o` = {page number, offset[11:0]}.
- R4: An access through a register with a clear tag traps with cause 1, whatever its range or permission.
- R5: With size code s (0,1,2,3 meaning 1,2,4,8 bytes), an access traps with cause 2 when offset + 2^s > 4096. Exactly 4096 is allowed. Range takes priority over permission.
- R6: A store without write permission traps with cause 3. A load without read permission traps with cause 4.
- R7: A generic write (`wr_valid_i`) replaces page number, permissions and virtual page of its register and clears the tag.
- R8: An invalidate (`inv_valid_i`) clears the tag and leaves the stored virtual page unchanged.
- R9: A re-translate command raises `tlb_req_valid_o` for exactly one cycle, in the next cycle, with the register index and its stored virtual page. The register keeps serving its old translation until a response arrives.
- R10: In a cycle where a generic write or an invalidate hits the same register as a stub response, the response is dropped. An access in that cycle sees the register's state from before the cycle.
- R11: Without an access, `acc_gnt_o` and `acc_trap_o` are 0. They are never 1 together. `acc_pa_o` is 0 unless granted.
- R12: Updates to one register leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tlb_rsp_valid_i | input | 1 | Stub response valid |
| tlb_rsp_idx_i | input | 2 | Register the response fills |
| tlb_rsp_vpn_i | input | 20 | Virtual page of the response |
| tlb_rsp_ppn_i | input | 20 | Physical page number |
| tlb_rsp_perm_i | input | 2 | Permissions, bit 0 read, bit 1 write |
| wr_valid_i | input | 1 | Generic/OS write valid (clears tag) |
| wr_idx_i | input | 2 | Register written |
| wr_vpn_i | input | 20 | Virtual page written |
| wr_ppn_i | input | 20 | Physical page written |
| wr_perm_i | input | 2 | Permissions written |
| inv_valid_i | input | 1 | Invalidate valid |
| inv_idx_i | input | 2 | Register invalidated |
| rtx_valid_i | input | 1 | Re-translate command |
| rtx_idx_i | input | 2 | Register to re-translate |
| tlb_req_valid_o | output | 1 | Request to the stub |
| tlb_req_idx_o | output | 2 | Register the request is for |
| tlb_req_vpn_o | output | 20 | Stored virtual page reissued |
| acc_valid_i | input | 1 | Access request |
| acc_idx_i | input | 2 | Register named by the access |
| acc_off_i | input | 14 | Byte offset from the page base |
| acc_size_i | input | 2 | Size code, bytes = 2^code |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_gnt_o | output | 1 | Access granted |
| acc_pa_o | output | 32 | Physical address when granted |
| acc_trap_o | output | 1 | Access trapped |
| acc_cause_o | output | 3 | 0 none, 1 tag clear, 2 range, 3 no write, 4 no read |

## Verification
The bench builds the unit with its default values: four registers, 4 KiB pages, a 14-bit offset, 2-bit size codes and a registered result. The offset is two bits wider than the page. That lets the bench drive offsets wholly past the page as well as accesses that start inside it and cross its end, including the exact 4096-byte limit. With four registers, one of them can stay untouched while the other three go through invalidates, generic writes, re-translates and same-cycle conflicts. That untouched register shows that state does not leak between registers.

// File: rtl/xlat_cap_pkg.sv
package xlat_cap_pkg;

   typedef enum logic [2:0] {
      XC_OK    = 3'd0,
      XC_NOTAG = 3'd1,
      XC_RANGE = 3'd2,
      XC_NOWR  = 3'd3,
      XC_NORD  = 3'd4
   } xc_cause_e;

   localparam int unsigned PERM_W  = 2;
   localparam int unsigned PERM_RD = 0;
   localparam int unsigned PERM_WR = 1;

endpackage

// File: rtl/xlat_reg_file.sv
module xlat_reg_file #(
   parameter int unsigned NREG  = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned PPN_W = 20,
   parameter int unsigned VPN_W = 20
) (
   input  logic                                    clk_i,
   input  logic                                    rst_ni,
   input  logic                                    rsp_valid_i,
   input  logic [IDX_W-1:0]                        rsp_idx_i,
   input  logic [VPN_W-1:0]                        rsp_vpn_i,
   input  logic [PPN_W-1:0]                        rsp_ppn_i,
   input  logic [xlat_cap_pkg::PERM_W-1:0]         rsp_perm_i,
   input  logic                                    wr_valid_i,
   input  logic [IDX_W-1:0]                        wr_idx_i,
   input  logic [VPN_W-1:0]                        wr_vpn_i,
   input  logic [PPN_W-1:0]                        wr_ppn_i,
   input  logic [xlat_cap_pkg::PERM_W-1:0]         wr_perm_i,
   input  logic                                    inv_valid_i,
   input  logic [IDX_W-1:0]                        inv_idx_i,
   output logic [NREG-1:0]                         tag_o,
   output logic [NREG-1:0][PPN_W-1:0]              ppn_o,
   output logic [NREG-1:0][xlat_cap_pkg::PERM_W-1:0] perm_o,
   output logic [NREG-1:0][VPN_W-1:0]              vpn_o
);
   import xlat_cap_pkg::*;

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      logic hit_rsp;
      logic hit_wr;
      logic hit_inv;

      assign hit_rsp = rsp_valid_i && (rsp_idx_i == IDX_W'(g));
      assign hit_wr  = wr_valid_i  && (wr_idx_i  == IDX_W'(g));
      assign hit_inv = inv_valid_i && (inv_idx_i == IDX_W'(g));

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            tag_o[g]  <= 1'b0;
            ppn_o[g]  <= '0;
            perm_o[g] <= '0;
            vpn_o[g]  <= '0;
         end else if (hit_wr) begin
            // plain write: fields replaced, capability lost
            tag_o[g]  <= 1'b0;
            ppn_o[g]  <= wr_ppn_i;
            perm_o[g] <= wr_perm_i;
            vpn_o[g]  <= wr_vpn_i;
         end else if (hit_inv) begin
            // R10: a colliding response is dropped
            tag_o[g]  <= 1'b0;
         end else if (hit_rsp) begin
            tag_o[g]  <= 1'b1;
            ppn_o[g]  <= rsp_ppn_i;
            perm_o[g] <= rsp_perm_i;
            vpn_o[g]  <= rsp_vpn_i;
         end
      end
   end

endmodule

// File: rtl/xlat_access_check.sv
module xlat_access_check #(
   parameter int unsigned PPN_W     = 20,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned OFF_W     = 14,
   parameter int unsigned SZ_W      = 2
) (
   input  logic                              tag_i,
   input  logic [PPN_W-1:0]                  ppn_i,
   input  logic [xlat_cap_pkg::PERM_W-1:0]   perm_i,
   input  logic [OFF_W-1:0]                  off_i,
   input  logic [SZ_W-1:0]                   size_i,
   input  logic                              store_i,
   output logic                              ok_o,
   output xlat_cap_pkg::xc_cause_e           cause_o,
   output logic [PPN_W+PAGE_BITS-1:0]        pa_o
);
   import xlat_cap_pkg::*;

   localparam int unsigned BYTES_W = 1 << SZ_W;
   localparam int unsigned END_W   = ((OFF_W > BYTES_W) ? OFF_W : BYTES_W) + 1;

   logic [END_W-1:0] span_end;
   logic [END_W-1:0] page_lim;
   logic             out_of_page;
   logic             perm_ok;

   assign page_lim    = END_W'(1) << PAGE_BITS;
   assign span_end    = END_W'(off_i) + (END_W'(1) << size_i);
   assign out_of_page = span_end > page_lim;
   assign perm_ok     = store_i ? perm_i[PERM_WR] : perm_i[PERM_RD];
   assign pa_o        = {ppn_i, off_i[PAGE_BITS-1:0]};

   // priority: tag, then range, then permission
   always_comb begin
      cause_o = XC_OK;
      if (!tag_i)           cause_o = XC_NOTAG;
      else if (out_of_page) cause_o = XC_RANGE;
      else if (!perm_ok)    cause_o = store_i ? XC_NOWR : XC_NORD;
   end

   assign ok_o = (cause_o == XC_OK);

endmodule

// File: rtl/xlat_retrans.sv
module xlat_retrans #(
   parameter int unsigned NREG  = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned VPN_W = 20
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         rtx_valid_i,
   input  logic [IDX_W-1:0]             rtx_idx_i,
   input  logic [NREG-1:0][VPN_W-1:0]   vpn_arr_i,
   output logic                         req_valid_o,
   output logic [IDX_W-1:0]             req_idx_o,
   output logic [VPN_W-1:0]             req_vpn_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         req_valid_o <= 1'b0;
         req_idx_o   <= '0;
         req_vpn_o   <= '0;
      end else begin
         req_valid_o <= rtx_valid_i;
         if (rtx_valid_i) begin
            req_idx_o <= rtx_idx_i;
            req_vpn_o <= vpn_arr_i[rtx_idx_i];
         end
      end
   end

endmodule

// File: rtl/xlat_cap_unit.sv
module xlat_cap_unit #(
   parameter int unsigned NREG       = 4,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned OFF_W      = 14,
   parameter int unsigned SZ_W       = 2,
   parameter bit          RESULT_REG = 1'b1,
   localparam int unsigned IDX_W     = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int unsigned PPN_W     = PA_W - PAGE_BITS,
   localparam int unsigned VPN_W     = VA_W - PAGE_BITS
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tlb_rsp_valid_i,
   input  logic [IDX_W-1:0]   tlb_rsp_idx_i,
   input  logic [VPN_W-1:0]   tlb_rsp_vpn_i,
   input  logic [PPN_W-1:0]   tlb_rsp_ppn_i,
   input  logic [1:0]         tlb_rsp_perm_i,
   input  logic               wr_valid_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [VPN_W-1:0]   wr_vpn_i,
   input  logic [PPN_W-1:0]   wr_ppn_i,
   input  logic [1:0]         wr_perm_i,
   input  logic               inv_valid_i,
   input  logic [IDX_W-1:0]   inv_idx_i,
   input  logic               rtx_valid_i,
   input  logic [IDX_W-1:0]   rtx_idx_i,
   output logic               tlb_req_valid_o,
   output logic [IDX_W-1:0]   tlb_req_idx_o,
   output logic [VPN_W-1:0]   tlb_req_vpn_o,
   input  logic               acc_valid_i,
   input  logic [IDX_W-1:0]   acc_idx_i,
   input  logic [OFF_W-1:0]   acc_off_i,
   input  logic [SZ_W-1:0]    acc_size_i,
   input  logic               acc_store_i,
   output logic               acc_gnt_o,
   output logic [PA_W-1:0]    acc_pa_o,
   output logic               acc_trap_o,
   output logic [2:0]         acc_cause_o
);
   import xlat_cap_pkg::*;

   // elaboration-time parameter checks
   if (PAGE_BITS >= PA_W || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("page size must be smaller than both address spaces");
   end
   if (OFF_W < PAGE_BITS) begin : g_bad_off
      $error("offset must cover a whole page");
   end
   if (NREG < 1) begin : g_bad_nreg
      $error("at least one translation register is required");
   end
   if (SZ_W < 1 || SZ_W > 3) begin : g_bad_sz
      $error("size code width out of range");
   end

   logic [NREG-1:0]              tag_q;
   logic [NREG-1:0][PPN_W-1:0]   ppn_q;
   logic [NREG-1:0][PERM_W-1:0]  perm_q;
   logic [NREG-1:0][VPN_W-1:0]   vpn_q;

   xlat_reg_file #(
      .NREG (NREG), .IDX_W(IDX_W), .PPN_W(PPN_W), .VPN_W(VPN_W)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rsp_valid_i (tlb_rsp_valid_i),
      .rsp_idx_i   (tlb_rsp_idx_i),
      .rsp_vpn_i   (tlb_rsp_vpn_i),
      .rsp_ppn_i   (tlb_rsp_ppn_i),
      .rsp_perm_i  (tlb_rsp_perm_i),
      .wr_valid_i  (wr_valid_i),
      .wr_idx_i    (wr_idx_i),
      .wr_vpn_i    (wr_vpn_i),
      .wr_ppn_i    (wr_ppn_i),
      .wr_perm_i   (wr_perm_i),
      .inv_valid_i (inv_valid_i),
      .inv_idx_i   (inv_idx_i),
      .tag_o       (tag_q),
      .ppn_o       (ppn_q),
      .perm_o      (perm_q),
      .vpn_o       (vpn_q)
   );

   xlat_retrans #(
      .NREG(NREG), .IDX_W(IDX_W), .VPN_W(VPN_W)
   ) u_rtx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rtx_valid_i (rtx_valid_i),
      .rtx_idx_i   (rtx_idx_i),
      .vpn_arr_i   (vpn_q),
      .req_valid_o (tlb_req_valid_o),
      .req_idx_o   (tlb_req_idx_o),
      .req_vpn_o   (tlb_req_vpn_o)
   );

   logic       chk_ok;
   xc_cause_e  chk_cause;
   logic [PA_W-1:0] chk_pa;

   xlat_access_check #(
      .PPN_W(PPN_W), .PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W), .SZ_W(SZ_W)
   ) u_chk (
      .tag_i   (tag_q[acc_idx_i]),
      .ppn_i   (ppn_q[acc_idx_i]),
      .perm_i  (perm_q[acc_idx_i]),
      .off_i   (acc_off_i),
      .size_i  (acc_size_i),
      .store_i (acc_store_i),
      .ok_o    (chk_ok),
      .cause_o (chk_cause),
      .pa_o    (chk_pa)
   );

   logic            nxt_gnt;
   logic            nxt_trap;
   logic [2:0]      nxt_cause;
   logic [PA_W-1:0] nxt_pa;

   assign nxt_gnt   = acc_valid_i && chk_ok;
   assign nxt_trap  = acc_valid_i && !chk_ok;
   assign nxt_cause = acc_valid_i ? chk_cause : XC_OK;
   assign nxt_pa    = nxt_gnt ? chk_pa : '0;   // no address leaks on a trap

   if (RESULT_REG) begin : g_res_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            acc_gnt_o   <= 1'b0;
            acc_trap_o  <= 1'b0;
            acc_cause_o <= XC_OK;
            acc_pa_o    <= '0;
         end else begin
            acc_gnt_o   <= nxt_gnt;
            acc_trap_o  <= nxt_trap;
            acc_cause_o <= nxt_cause;
            acc_pa_o    <= nxt_pa;
         end
      end
   end else begin : g_res_comb
      assign acc_gnt_o   = nxt_gnt;
      assign acc_trap_o  = nxt_trap;
      assign acc_cause_o = nxt_cause;
      assign acc_pa_o    = nxt_pa;
   end

endmodule

// File: rtl/xlat_cap_chk.sv
module xlat_cap_chk #(
   parameter int unsigned NREG       = 4,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned OFF_W      = 14,
   parameter bit          RESULT_REG = 1'b1
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 acc_valid_i,
   input logic [IDX_W-1:0]     acc_idx_i,
   input logic [OFF_W-1:0]     acc_off_i,
   input logic                 inv_valid_i,
   input logic [IDX_W-1:0]     inv_idx_i,
   input logic                 wr_valid_i,
   input logic [IDX_W-1:0]     wr_idx_i,
   input logic                 tlb_rsp_valid_i,
   input logic [IDX_W-1:0]     tlb_rsp_idx_i,
   input logic                 rtx_valid_i,
   input logic [IDX_W-1:0]     rtx_idx_i,
   input logic [NREG-1:0]      tag_q,
   input logic                 acc_gnt_o,
   input logic                 acc_trap_o,
   input logic [2:0]           acc_cause_o,
   input logic [PAGE_BITS-1:0] acc_pa_lo,
   input logic                 tlb_req_valid_o,
   input logic [IDX_W-1:0]     tlb_req_idx_o
);

   a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(acc_gnt_o && acc_trap_o));

   a_r3_gnt_no_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_gnt_o |-> acc_cause_o == 3'd0);

   a_r4_trap_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_trap_o |-> acc_cause_o != 3'd0);

   a_r8_inv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inv_valid_i |=> !tag_q[$past(inv_idx_i)]);

   a_r7_wr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_i |=> !tag_q[$past(wr_idx_i)]);

   a_r2_rsp_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tlb_rsp_valid_i && !(inv_valid_i && inv_idx_i == tlb_rsp_idx_i)
         && !(wr_valid_i && wr_idx_i == tlb_rsp_idx_i)
      |=> tag_q[$past(tlb_rsp_idx_i)]);

   a_r9_rtx_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rtx_valid_i |=> tlb_req_valid_o && tlb_req_idx_o == $past(rtx_idx_i));

   a_r9_rtx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rtx_valid_i |=> !tlb_req_valid_o);

   if (RESULT_REG) begin : g_timed
      a_r4_notag_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
         acc_valid_i && !tag_q[acc_idx_i] |=> acc_trap_o && acc_cause_o == 3'd1);

      a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !acc_valid_i |=> !acc_gnt_o && !acc_trap_o);

      a_r3_pa_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
         acc_gnt_o |-> acc_pa_lo == $past(acc_off_i[PAGE_BITS-1:0]));

      if (OFF_W > PAGE_BITS) begin : g_far
         a_r5_far_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
            acc_valid_i && tag_q[acc_idx_i] && (acc_off_i[OFF_W-1:PAGE_BITS] != '0)
            |=> acc_trap_o && acc_cause_o == 3'd2);
      end
   end

endmodule

bind xlat_cap_unit xlat_cap_chk #(
   .NREG(NREG), .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W),
   .RESULT_REG(RESULT_REG)
) u_xlat_cap_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .acc_valid_i     (acc_valid_i),
   .acc_idx_i       (acc_idx_i),
   .acc_off_i       (acc_off_i),
   .inv_valid_i     (inv_valid_i),
   .inv_idx_i       (inv_idx_i),
   .wr_valid_i      (wr_valid_i),
   .wr_idx_i        (wr_idx_i),
   .tlb_rsp_valid_i (tlb_rsp_valid_i),
   .tlb_rsp_idx_i   (tlb_rsp_idx_i),
   .rtx_valid_i     (rtx_valid_i),
   .rtx_idx_i       (rtx_idx_i),
   .tag_q           (tag_q),
   .acc_gnt_o       (acc_gnt_o),
   .acc_trap_o      (acc_trap_o),
   .acc_cause_o     (acc_cause_o),
   .acc_pa_lo       (acc_pa_o[PAGE_BITS-1:0]),
   .tlb_req_valid_o (tlb_req_valid_o),
   .tlb_req_idx_o   (tlb_req_idx_o)
);

// File: tb/test_xlat_cap_unit.sv
module test_xlat_cap_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rsp_v = 0, wr_v = 0, inv_v = 0, rtx_v = 0, acc_v = 0;
   logic [1:0]  rsp_idx = 0, wr_idx = 0, inv_idx = 0, rtx_idx = 0, acc_idx = 0;
   logic [19:0] rsp_vpn = 0, rsp_ppn = 0, wr_vpn = 0, wr_ppn = 0;
   logic [1:0]  rsp_perm = 0, wr_perm = 0;
   logic [13:0] acc_off = 0;
   logic [1:0]  acc_size = 0;
   logic        acc_st = 0;
   logic        req_v;
   logic [1:0]  req_idx;
   logic [19:0] req_vpn;
   logic        gnt, trap;
   logic [31:0] pa;
   logic [2:0]  cause;

   xlat_cap_unit i_xlat_cap_unit (
      .clk_i(clk), .rst_ni(rst_n),
      .tlb_rsp_valid_i(rsp_v), .tlb_rsp_idx_i(rsp_idx), .tlb_rsp_vpn_i(rsp_vpn),
      .tlb_rsp_ppn_i(rsp_ppn), .tlb_rsp_perm_i(rsp_perm),
      .wr_valid_i(wr_v), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn),
      .wr_ppn_i(wr_ppn), .wr_perm_i(wr_perm),
      .inv_valid_i(inv_v), .inv_idx_i(inv_idx),
      .rtx_valid_i(rtx_v), .rtx_idx_i(rtx_idx),
      .tlb_req_valid_o(req_v), .tlb_req_idx_o(req_idx), .tlb_req_vpn_o(req_vpn),
      .acc_valid_i(acc_v), .acc_idx_i(acc_idx), .acc_off_i(acc_off),
      .acc_size_i(acc_size), .acc_store_i(acc_st),
      .acc_gnt_o(gnt), .acc_pa_o(pa), .acc_trap_o(trap), .acc_cause_o(cause)
   );

   always #10 clk = ~clk;   // 50 MHz

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct packed {
      logic        gnt;
      logic        trap;
      logic [2:0]  cause;
      logic [31:0] pa;
   } exp_t;

   exp_t  eq[$];
   string tq[$];

   // bench-side model of the registers
   bit          mtag [4];
   logic [19:0] mppn [4];
   logic [1:0]  mperm[4];
   logic [19:0] mvpn [4];

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
      end
   endtask

   task automatic step();
      @(negedge clk);
      rsp_v = 0; wr_v = 0; inv_v = 0; rtx_v = 0; acc_v = 0;
   endtask

   // driver: compute expectation from the model, push it, drive the access
   task automatic push_acc(input int idx, input int off, input int sz,
                           input bit st, input string rq);
      exp_t e;
      logic [31:0] o;
      o = off;
      e = '0;
      if (!mtag[idx])                   e.cause = 3'd1;
      else if (off + (1 << sz) > 4096)  e.cause = 3'd2;
      else if (st && !mperm[idx][1])    e.cause = 3'd3;
      else if (!st && !mperm[idx][0])   e.cause = 3'd4;
      if (e.cause == 3'd0) begin
         e.gnt = 1'b1;
         e.pa  = {mppn[idx], o[11:0]};
      end else begin
         e.trap = 1'b1;
      end
      eq.push_back(e);
      tq.push_back(rq);
      acc_v = 1; acc_idx = 2'(idx); acc_off = 14'(off);
      acc_size = 2'(sz); acc_st = st;
   endtask

   task automatic acc(input int idx, input int off, input int sz,
                      input bit st, input string rq);
      push_acc(idx, off, sz, st, rq);
      step();
   endtask

   task automatic set_rsp(input int idx, input logic [19:0] vpn,
                          input logic [19:0] ppn, input logic [1:0] perm);
      rsp_v = 1; rsp_idx = 2'(idx); rsp_vpn = vpn; rsp_ppn = ppn; rsp_perm = perm;
   endtask

   task automatic set_wr(input int idx, input logic [19:0] vpn,
                         input logic [19:0] ppn, input logic [1:0] perm);
      wr_v = 1; wr_idx = 2'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_perm = perm;
   endtask

   task automatic rsp(input int idx, input logic [19:0] vpn,
                      input logic [19:0] ppn, input logic [1:0] perm);
      set_rsp(idx, vpn, ppn, perm);
      mtag[idx] = 1; mvpn[idx] = vpn; mppn[idx] = ppn; mperm[idx] = perm;
      step();
   endtask

   task automatic rtx(input int idx, input string rq);
      rtx_v = 1; rtx_idx = 2'(idx);
      step();
      chk(req_v == 1'b1, rq, "req_valid", 64'(req_v), 64'd1);
      chk(req_idx == 2'(idx), rq, "req_idx", 64'(req_idx), 64'(idx));
      chk(req_vpn == mvpn[idx], rq, "req_vpn", 64'(req_vpn), 64'(mvpn[idx]));
      step();
      chk(req_v == 1'b0, rq, "req_valid drop", 64'(req_v), 64'd0);
   endtask

   // monitor: pops one expectation per accepted access
   logic pend = 0;
   always @(posedge clk) pend <= rst_n && acc_v;

   always @(negedge clk) begin
      if (pend) begin
         exp_t  e;
         string rq;
         if (eq.size() == 0) begin
            chk(1'b0, "R3", "unexpected result", 64'(gnt), 64'd0);
         end else begin
            e  = eq.pop_front();
            rq = tq.pop_front();
            chk(gnt == e.gnt && trap == e.trap && cause == e.cause && pa == e.pa,
                rq, "gnt/trap/cause/pa",
                {27'd0, gnt, trap, cause, pa}, {27'd0, e.gnt, e.trap, e.cause, e.pa});
         end
      end else if (rst_n) begin
         chk(!gnt && !trap && pa == 32'd0, "R11", "idle outputs",
             {62'd0, gnt, trap}, 64'd0);
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         mtag[i] = 0; mppn[i] = 0; mperm[i] = 0; mvpn[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk(!gnt && !trap && !req_v, "R1", "reset outputs",
          {61'd0, gnt, trap, req_v}, 64'd0);
      for (int i = 0; i < 4; i++) acc(i, 0, 0, 0, "R1");

      rsp(0, 20'hABCDE, 20'h12345, 2'b11);
      rsp(3, 20'h33333, 20'h0BEEF, 2'b11);
      rsp(1, 20'h11000, 20'h22222, 2'b01);
      rsp(2, 20'h22000, 20'h44444, 2'b10);

      acc(0, 'h010, 2, 0, "R2_R3");
      acc(0, 'hFF8, 3, 1, "R5 boundary");
      acc(0, 'hFF9, 3, 1, "R5");
      acc(0, 'hFFF, 0, 0, "R5 last byte");
      acc(0, 'h1000, 0, 0, "R5");
      acc(0, 'h3FFF, 3, 0, "R5");
      acc(1, 'h100, 1, 1, "R6 no write");
      acc(1, 'hFFE, 2, 1, "R5 over R6");
      acc(1, 'h100, 0, 0, "R3");
      acc(2, 'h020, 0, 0, "R6 no read");
      acc(2, 'h020, 3, 1, "R3");

      // R8: invalidate; tag priority over range
      inv_v = 1; inv_idx = 0; mtag[0] = 0; step();
      acc(0, 'h1000, 3, 1, "R4 R8");
      rtx(0, "R8");

      // R7: generic write
      set_wr(1, 20'h5A5A5, 20'h77777, 2'b11);
      mtag[1] = 0; mvpn[1] = 20'h5A5A5; mppn[1] = 20'h77777; mperm[1] = 2'b11;
      step();
      acc(1, 'h008, 0, 0, "R7");
      rtx(1, "R7");
      rsp(1, 20'h5A5A5, 20'h66666, 2'b11);
      acc(1, 'h008, 2, 0, "R2 R9");

      // R9: old translation serves until the response
      rtx(2, "R9");
      acc(2, 'h030, 1, 1, "R9");

      // R10: write vs response, access sees old state
      push_acc(2, 'h040, 0, 1, "R10 old state");
      set_rsp(2, 20'h22000, 20'h55555, 2'b11);
      set_wr(2, 20'h0AAAA, 20'h99999, 2'b11);
      mtag[2] = 0; mvpn[2] = 20'h0AAAA; mppn[2] = 20'h99999; mperm[2] = 2'b11;
      step();
      acc(2, 'h040, 0, 0, "R10 write wins");
      rtx(2, "R10");
      // R10: invalidate vs response
      set_rsp(2, 20'h12121, 20'h55555, 2'b11);
      inv_v = 1; inv_idx = 2;
      step();
      acc(2, 'h000, 0, 0, "R10 inv wins");
      rtx(2, "R10 vpn kept");
      rsp(2, 20'h0AAAA, 20'h55555, 2'b11);
      acc(2, 'h000, 0, 0, "R2");

      // R12: untouched register
      acc(3, 'h7F0, 2, 0, "R12");
      acc(3, 'hFFC, 2, 1, "R12");

      repeat (3) step();
      chk(eq.size() == 0, "R3", "pending results", 64'(eq.size()), 64'd0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule